// File: doc/BRIEF.md
# Shared-Word Event Interrupt Aggregator

This block gathers a small set of system events into one active-high level interrupt for a parent interrupt controller. Some events come in as one-cycle pulses. Others come from reset-type input lines. Each reset line passes through a two-flop synchroniser and an edge detector, and its upward and downward transitions are reported as two separate sources. Every source has a sticky pending bit and an enable bit. The combined output is high while any source is both pending and enabled.

Software uses one 32-bit word for both the enable mask and the pending status. The enables sit in the low half. The pending bit of each source is exactly 16 positions above its enable bit. A write loads the enable field from the written value and, in the same write, clears every pending bit written as 1. Software therefore writes back its current enables together with the status bits it has just serviced. The placement of the source field is set by parameters, a base offset and a count, so the same block covers several layouts.

In the default layout there are seven sources at bits 0 to 6. Source 0 is a cursor-change pulse and source 1 a scratch-register-change pulse. Sources 2 to 5 are the rise and fall events of two reset lines. Source 6 is a further pulse event.

Top module: `sysirq_agg`

## Requirements
- R1: For source n, the enable bit reads back at bit SRC_BASE+n of `reg_rdata_o` and the pending bit at bit SRC_BASE+n+16.
- R2: After reset, every enable bit and every pending bit is 0, and `irq_o` is low.
- R3: A pulse on `evt_pulse_i[n]`, sampled at a rising clock edge, makes source n pending from that edge on, whether or not the source is enabled.
- R4: Line i maps to source LINE_FIRST+2i for a low-to-high change and to source LINE_FIRST+2i+1 for a high-to-low change. The pending bit is set at the third rising clock edge after the line changes.
- R5: A write clears each pending bit whose status position in `reg_wdata_i` is 1. A pending bit whose status position is written as 0 stays pending.
- R6: Every write replaces the whole enable field with the written enable bits. With no write, the enables hold.
- R7: If a source's event and a write-one-to-clear of that source's pending bit arrive at the same edge, the bit stays pending.
- R8: `irq_o` is high exactly when at least one source is both pending and enabled.
- R9: Bits outside the two configured fields always read 0, and writing them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | SRC_COUNT | One-cycle event pulses, one per source |
| line_i | input | LINE_COUNT | Asynchronous reset-type lines whose edges raise events |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data: enables low, pending bits high |
| irq_o | output | 1 | Combined level interrupt to the parent |

## Verification
The assertions assume that software follows the rule that every write carries the whole enable field. They also assume that an event pulse lasts one cycle and that `line_i` is low while reset is applied, so no edge appears at reset release. The stimulus keeps to these rules. Pulses are driven for exactly one cycle, lines change only after reset has been released, and every write, including the random ones, drives a full 32-bit value. The random writes often set reserved bits and status bits together with the enables, which exercises R9 and the R7 set-against-clear race.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;
  localparam int REG_W      = 32;
  localparam int STAT_SHIFT = 16;
endpackage

// File: rtl/sysirq_line_edge.sv
module sysirq_line_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, meta_d;
  logic sync_q, sync_d;
  logic last_q, last_d;

  always_comb begin
    meta_d = line_i;
    sync_d = meta_q;
    last_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_o = sync_q & ~last_q;
  assign fall_o = ~sync_q & last_q;

  // R4: after a rise report the synchronised line is seen high
  a_r4_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> (last_q && !rise_o));
endmodule

// File: rtl/sysirq_enable_reg.sv
module sysirq_enable_reg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(wdata_i)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/sysirq_pend_bank.sv
module sysirq_pend_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d;

  // a set outranks a clear of the same bit
  always_comb begin
    pend_d = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/sysirq_agg.sv
module sysirq_agg
  import sysirq_pkg::*;
#(
  parameter int SRC_BASE   = 0,
  parameter int SRC_COUNT  = 7,
  parameter int LINE_COUNT = 2,
  parameter int LINE_FIRST = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SRC_COUNT-1:0]  evt_pulse_i,
  input  logic [LINE_COUNT-1:0] line_i,
  input  logic                  reg_wr_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o,
  output logic                  irq_o
);
  localparam int EN_LSB = SRC_BASE;
  localparam int ST_LSB = SRC_BASE + STAT_SHIFT;

  logic [LINE_COUNT-1:0] rise_w, fall_w;
  logic [SRC_COUNT-1:0]  edge_evt, set_vec, clr_vec, en_vec, pend_vec;
  logic                  wr_unused;

  genvar gi;
  generate
    for (gi = 0; gi < LINE_COUNT; gi++) begin : g_line
      sysirq_line_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i[gi]),
        .rise_o (rise_w[gi]),
        .fall_o (fall_w[gi])
      );
    end
  endgenerate

  always_comb begin
    edge_evt = '0;
    for (int i = 0; i < LINE_COUNT; i++) begin
      edge_evt[LINE_FIRST + 2*i]     = rise_w[i];
      edge_evt[LINE_FIRST + 2*i + 1] = fall_w[i];
    end
    set_vec = evt_pulse_i | edge_evt;
    clr_vec = reg_wr_i ? reg_wdata_i[ST_LSB +: SRC_COUNT] : '0;
  end

  sysirq_enable_reg #(.N(SRC_COUNT)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i[EN_LSB +: SRC_COUNT]),
    .en_o    (en_vec)
  );

  sysirq_pend_bank #(.N(SRC_COUNT)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend_vec)
  );

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[EN_LSB +: SRC_COUNT] = en_vec;
    reg_rdata_o[ST_LSB +: SRC_COUNT] = pend_vec;
  end

  assign irq_o     = |(en_vec & pend_vec);
  assign wr_unused = ^reg_wdata_i;

  // R8: the output can only rise after an event or a register write
  a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(reg_wr_i || (set_vec != '0)));
  // R8: with no write the output cannot fall
  a_r8_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_i && irq_o) |=> irq_o);
endmodule

// File: tb/sysirq_agg_tb_top.sv
module sysirq_agg_tb_top;
  localparam int B  = 0;
  localparam int N  = 7;
  localparam int NL = 2;
  localparam int LF = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  evt_pulse;
  logic [NL-1:0] line;
  logic          wr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  bit m_en [N];
  bit m_st [N];
  int s1 [NL];
  int s2 [NL];
  int s3 [NL];

  always #10 clk = ~clk;

  sysirq_agg #(.SRC_BASE(B), .SRC_COUNT(N), .LINE_COUNT(NL), .LINE_FIRST(LF)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse_i (evt_pulse),
    .line_i      (line),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int n = 0; n < N; n++) begin
      w[B+n]    = m_en[n];
      w[B+n+16] = m_st[n];
    end
    return w;
  endfunction

  function automatic logic model_irq();
    logic r = 1'b0;
    for (int n = 0; n < N; n++) r |= (m_en[n] & m_st[n]);
    return r;
  endfunction

  // advance the reference by one clock using the inputs applied during it
  task automatic model_step();
    bit ev [N];
    if (!rst_n) begin
      for (int n = 0; n < N; n++) begin m_en[n] = 0; m_st[n] = 0; end
      for (int i = 0; i < NL; i++) begin s1[i] = 0; s2[i] = 0; s3[i] = 0; end
      return;
    end
    for (int n = 0; n < N; n++) ev[n] = evt_pulse[n];
    for (int i = 0; i < NL; i++)
      if (s2[i] != s3[i]) ev[LF + 2*i + (s2[i] != 0 ? 0 : 1)] = 1;
    if (wr)
      for (int n = 0; n < N; n++) begin
        m_en[n] = wdata[B+n];
        if (wdata[B+n+16]) m_st[n] = 0;
      end
    for (int n = 0; n < N; n++) if (ev[n]) m_st[n] = 1;
    for (int i = 0; i < NL; i++) begin
      s3[i] = s2[i]; s2[i] = s1[i]; s1[i] = line[i];
    end
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    check("R1 rdata vs model", rdata, model_word());
    check("R8 irq vs model", {31'b0, irq}, {31'b0, model_irq()});
  endtask

  task automatic idle();
    evt_pulse = '0; wr = 1'b0; wdata = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line = '0; idle();
    tick(); tick(); tick();
    check("R2 reset word", rdata, 32'h0);
    check("R2 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R3: pulse while disabled
    evt_pulse = 7'b0000001; tick(); idle();
    check("R3 pending while disabled", rdata, 32'h0001_0000);
    check("R8 disabled no irq", {31'b0, irq}, 32'h0);
    tick();
    check("R3 pending sticky", rdata, 32'h0001_0000);

    // R1/R8: enable source 0
    wr = 1; wdata = 32'h0000_0001; tick(); idle();
    check("R1 layout", rdata, 32'h0001_0001);
    check("R8 irq high", {31'b0, irq}, 32'h1);

    // R5: clear with enable carried
    wr = 1; wdata = 32'h0001_0001; tick(); idle();
    check("R5 cleared", rdata, 32'h0000_0001);
    check("R5 irq low", {31'b0, irq}, 32'h0);

    // R5: writing 0 to a pending bit keeps it
    evt_pulse = 7'b0000010; tick(); idle();
    wr = 1; wdata = 32'h0000_0001; tick(); idle();
    check("R5 zero keeps pending", rdata, 32'h0002_0001);

    // R4: line 0 rise -> source 2 on third edge
    line[0] = 1'b1; tick();
    tick();
    check("R4 not yet after two edges", rdata & 32'h0004_0000, 32'h0);
    tick();
    check("R4 rise source 2", rdata & 32'h0004_0000, 32'h0004_0000);
    line[0] = 1'b0; tick(); tick(); tick();
    check("R4 fall source 3", rdata & 32'h0008_0000, 32'h0008_0000);
    line[1] = 1'b1; tick(); tick(); tick();
    check("R4 line 1 rise source 4", rdata & 32'h0030_0000, 32'h0010_0000);
    line[1] = 1'b0; tick(); tick(); tick();
    check("R4 line 1 fall source 5", rdata & 32'h0020_0000, 32'h0020_0000);

    // R7: set against clear on source 6
    evt_pulse = 7'b1000000; wr = 1; wdata = 32'h007F_0000; tick(); idle();
    check("R7 set wins", rdata, 32'h0040_0000);

    // R6: enable field replaced
    wr = 1; wdata = 32'h0000_007F; tick(); idle();
    check("R6 all enabled", rdata & 32'hFFFF, 32'h007F);
    wr = 1; wdata = 32'h0000_0008; tick(); idle();
    check("R6 replaced", rdata & 32'hFFFF, 32'h0008);
    check("R8 src6 pending but masked", {31'b0, irq}, 32'h0);

    // R9: reserved bits ignored
    wr = 1; wdata = 32'hFFFF_FFFF; tick(); idle();
    check("R9 reserved zero", rdata, 32'h0000_007F);
    wr = 1; wdata = 32'hFF80_FF80; tick(); idle();
    check("R9 reserved write ignored", rdata, 32'h0000_0000);

    // random traffic, compared against the model every clock
    for (int k = 0; k < 2000; k++) begin
      evt_pulse = '0;
      if ($urandom_range(0, 3) == 0) evt_pulse = N'($urandom);
      if ($urandom_range(0, 15) == 0) line[$urandom_range(0, NL-1)] ^= 1'b1;
      wr = ($urandom_range(0, 4) == 0);
      wdata = $urandom;
      tick();
    end
    idle(); tick();

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule